// File: doc/BRIEF.md
# Memory-Mapped Character Port

This block is a small character I/O peripheral on a word-addressed bus with a 12-bit address. It claims the four highest addresses. The two lower ones belong to the receive channel and the two upper ones to the transmit channel. Each channel has one data word and one control word. Software enables a channel through its control word. It then polls two status flags to learn whether a character is waiting or whether the transmitter can take another one.

On the device side, a receive strobe presents one byte. A transmit-valid output holds a byte until the device pulses its ready input, which marks that the transmission has finished. Serial framing, baud generation and interrupt delivery belong to other blocks. The Interrupt flag is only stored here.

Top module: `mmio_char_port`

## Requirements
- R1: After reset all control bits read 0, both data words read 0 and `tx_valid` is low. An asynchronous reset assertion takes effect without waiting for a clock edge.
- R2: The address map is 0xFFC receive data, 0xFFD receive control, 0xFFE transmit data and 0xFFF transmit control. Data words read the character in bits 7:0 with zeros above. Any other address reads 0, and a write to it changes nothing.
- R3: A control word reads {12'b0, On, Interrupt, Done, Busy}, with On in bit 3 and Busy in bit 0. A control write takes On from wdata bit 3 and Interrupt from bit 2 and ignores every other bit. When the receiver goes from Off to On it reads Done=0, Busy=1.
- R4: When the transmitter goes from Off to On it reads Done=1, Busy=0. A write that clears On makes Done=0 and Busy=0 on either channel.
- R5: A `rx_valid` pulse while the receiver is On stores `rx_char` and sets Done=1, Busy=0 from the next cycle. While the receiver is Off the pulse changes nothing.
- R6: A read of the receive data word while Done=1 returns the stored character and then sets Done=0, Busy=1. A read while Done=0 changes nothing. A `rx_valid` pulse in the same cycle as that read wins, and a new character arriving while Done=1 replaces the stored one.
- R7: A write to the transmit data word while the transmitter is On with Done=1 stores wdata bits 7:0 and sets Done=0, Busy=1. From the next cycle `tx_valid` is high and `tx_char` shows the byte. The write is ignored while the transmitter is Off or Busy.
- R8: A cycle with `tx_valid` and `tx_ready` both high sets Done=1, Busy=0 and drops `tx_valid` in the next cycle. The stored byte is kept.
- R9: The Interrupt bit reads back as written and never changes Done or Busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 12 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the receive-data side effect depends on it |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_char | input | 8 | Received byte |
| tx_valid | output | 1 | A byte is being transmitted |
| tx_char | output | 8 | Byte to transmit |
| tx_ready | input | 1 | The device has finished the current byte |

## Verification
A wrong Done or Busy flag shows up on the next control-word read. A stuck Busy on the transmit side also shows up as `tx_valid` staying high one cycle after a ready handshake. A lost receive character shows up on the data-word read that follows the strobe. A read that fails to clear Done shows up on the control read one cycle later. Because the read data is combinational, every stored state is visible one cycle after the edge that changed it.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  // Bit positions of the status nibble in a control word
  localparam int unsigned ST_ON   = 3;
  localparam int unsigned ST_INT  = 2;
  localparam int unsigned ST_DONE = 1;
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_W    = 4;

  typedef logic [1:0] flag_pair_t;  // {done, busy}
  localparam flag_pair_t FL_IDLE = 2'b00;
  localparam flag_pair_t FL_WAIT = 2'b01;
  localparam flag_pair_t FL_HAVE = 2'b10;
endpackage

// File: rtl/mcp_rst_sync.sv
module mcp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mcp_rx_chan.sv
module mcp_rx_chan
  import mcp_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_on,
  input  logic              ctl_int,
  input  logic              data_re,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic [ST_W-1:0]   stat,
  output logic [CHAR_W-1:0] char_q
);
  logic       on_q, on_d, int_q, int_d;
  flag_pair_t fl_q, fl_d;
  logic [CHAR_W-1:0] char_d;
  logic       cap_en;

  always_comb begin
    on_d   = on_q;
    int_d  = int_q;
    fl_d   = fl_q;
    cap_en = 1'b0;
    if (ctl_we) begin
      on_d  = ctl_on;
      int_d = ctl_int;
      if (!ctl_on)    fl_d = FL_IDLE;
      else if (!on_q) fl_d = FL_WAIT;
    end
    if (on_q && on_d && data_re && fl_q[1]) fl_d = FL_WAIT;
    if (on_q && on_d && in_valid) begin
      fl_d   = FL_HAVE;
      cap_en = 1'b1;
    end
  end

  assign char_d = cap_en ? in_char : char_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      int_q  <= 1'b0;
      fl_q   <= FL_IDLE;
      char_q <= '0;
    end else begin
      on_q  <= on_d;
      int_q <= int_d;
      fl_q  <= fl_d;
      if (cap_en) char_q <= char_d;
    end
  end

  assign stat = {on_q, int_q, fl_q};
endmodule

// File: rtl/mcp_tx_chan.sv
module mcp_tx_chan
  import mcp_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_on,
  input  logic              ctl_int,
  input  logic              data_we,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              dev_ready,
  output logic [ST_W-1:0]   stat,
  output logic [CHAR_W-1:0] char_q,
  output logic              dev_valid
);
  logic       on_q, on_d, int_q, int_d;
  flag_pair_t fl_q, fl_d;
  logic       load_en;

  always_comb begin
    on_d    = on_q;
    int_d   = int_q;
    fl_d    = fl_q;
    load_en = 1'b0;
    if (ctl_we) begin
      on_d  = ctl_on;
      int_d = ctl_int;
      if (!ctl_on)    fl_d = FL_IDLE;
      else if (!on_q) fl_d = FL_HAVE;
    end
    if (on_q && on_d && data_we && fl_q[1]) begin
      fl_d    = FL_WAIT;
      load_en = 1'b1;
    end else if (on_q && on_d && fl_q[0] && dev_ready) begin
      fl_d = FL_HAVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      int_q  <= 1'b0;
      fl_q   <= FL_IDLE;
      char_q <= '0;
    end else begin
      on_q  <= on_d;
      int_q <= int_d;
      fl_q  <= fl_d;
      if (load_en) char_q <= wchar;
    end
  end

  assign stat      = {on_q, int_q, fl_q};
  assign dev_valid = fl_q[0];
endmodule

// File: rtl/mmio_char_port.sv
module mmio_char_port
  import mcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              tx_ready
);
  localparam logic [ADDR_W-1:0] A_TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_RXD = A_TOP - ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RXC = A_TOP - ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TXD = A_TOP - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TXC = A_TOP;

  logic rst_s_n;
  logic sel_rxd, sel_rxc, sel_txd, sel_txc;
  logic [ST_W-1:0]   rx_stat, tx_stat;
  logic [CHAR_W-1:0] rx_data;
  logic unused_wbits;

  mcp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign sel_rxd = (bus_addr == A_RXD);
  assign sel_rxc = (bus_addr == A_RXC);
  assign sel_txd = (bus_addr == A_TXD);
  assign sel_txc = (bus_addr == A_TXC);

  mcp_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n),
    .ctl_we(bus_wr && sel_rxc),
    .ctl_on(bus_wdata[ST_ON]), .ctl_int(bus_wdata[ST_INT]),
    .data_re(bus_rd && sel_rxd),
    .in_valid(rx_valid), .in_char(rx_char),
    .stat(rx_stat), .char_q(rx_data)
  );

  mcp_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n),
    .ctl_we(bus_wr && sel_txc),
    .ctl_on(bus_wdata[ST_ON]), .ctl_int(bus_wdata[ST_INT]),
    .data_we(bus_wr && sel_txd),
    .wchar(bus_wdata[CHAR_W-1:0]),
    .dev_ready(tx_ready),
    .stat(tx_stat), .char_q(tx_char), .dev_valid(tx_valid)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel_rxd: bus_rdata = {{(DATA_W-CHAR_W){1'b0}}, rx_data};
      sel_rxc: bus_rdata = {{(DATA_W-ST_W){1'b0}}, rx_stat};
      sel_txd: bus_rdata = {{(DATA_W-CHAR_W){1'b0}}, tx_char};
      sel_txc: bus_rdata = {{(DATA_W-ST_W){1'b0}}, tx_stat};
      default: bus_rdata = '0;
    endcase
  end

  assign unused_wbits = ^bus_wdata[DATA_W-1:CHAR_W];
endmodule

// File: rtl/mmio_char_port_chk.sv
module mmio_char_port_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [3:0]        rx_stat,
  input logic [3:0]        tx_stat
);
  localparam logic [ADDR_W-1:0] A_TOP = {ADDR_W{1'b1}};

  // R2
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_addr == A_TOP || bus_addr == A_TOP - ADDR_W'(2)) |-> (bus_rdata[DATA_W-1:4] == '0));

  // R4
  off_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!rx_stat[3] |-> rx_stat[1:0] == 2'b00) and (!tx_stat[3] |-> tx_stat[1:0] == 2'b00));

  // R3
  on_one_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_stat[3] |-> (rx_stat[1] ^ rx_stat[0])) and (tx_stat[3] |-> (tx_stat[1] ^ tx_stat[0])));

  // R5
  rx_arrival_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_valid && rx_stat[3] && !(bus_wr && bus_addr == A_TOP - ADDR_W'(2) && !bus_wdata[3]))
      |=> (rx_stat[1] && !rx_stat[0]));

  // R7
  tx_off_write_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && bus_addr == A_TOP - ADDR_W'(1) && !tx_stat[3]) |=> !tx_valid);

  // R8
  tx_handshake_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tx_valid && tx_ready) |=> !tx_valid);
endmodule

bind mmio_char_port mmio_char_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_stat(rx_stat), .tx_stat(tx_stat)
);

// File: tb/mmio_char_port_tb_top.sv
module mmio_char_port_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 41;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RX = 3'd2, OP_CHK = 3'd3, OP_ACK = 3'd4;

  logic        clk, rst_n, bus_wr, bus_rd, rx_valid, tx_valid, tx_ready;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0]  rx_char, tx_char;
  int checks = 0, failures = 0;

  mmio_char_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_char(rx_char),
    .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {op, addr, wdata, expected, requirement}
  localparam logic [50:0] VEC [NV] = '{
    {OP_RD, 12'hFFD, 16'h0000, 16'h0000, 4'd1},  // R1
    {OP_RD, 12'hFFF, 16'h0000, 16'h0000, 4'd1},
    {OP_RD, 12'hFFC, 16'h0000, 16'h0000, 4'd1},
    {OP_CHK,12'h000, 16'h0000, 16'h0000, 4'd1},
    {OP_RX, 12'h000, 16'h0041, 16'h0000, 4'd5},  // R5 receiver off
    {OP_RD, 12'hFFD, 16'h0000, 16'h0000, 4'd5},
    {OP_RD, 12'hFFC, 16'h0000, 16'h0000, 4'd5},
    {OP_WR, 12'hFFD, 16'h0008, 16'h0000, 4'd3},  // R3 receiver on
    {OP_RD, 12'hFFD, 16'h0000, 16'h0009, 4'd3},
    {OP_RX, 12'h000, 16'h0041, 16'h0000, 4'd5},
    {OP_RD, 12'hFFD, 16'h0000, 16'h000A, 4'd5},
    {OP_RD, 12'hFFC, 16'h0000, 16'h0041, 4'd6},  // R6 read clears Done
    {OP_RD, 12'hFFD, 16'h0000, 16'h0009, 4'd6},
    {OP_RD, 12'hFFC, 16'h0000, 16'h0041, 4'd6},
    {OP_RD, 12'hFFD, 16'h0000, 16'h0009, 4'd6},
    {OP_WR, 12'hFFD, 16'h000C, 16'h0000, 4'd9},  // R9
    {OP_RD, 12'hFFD, 16'h0000, 16'h000D, 4'd9},
    {OP_WR, 12'hFFD, 16'h00FB, 16'h0000, 4'd3},
    {OP_RD, 12'hFFD, 16'h0000, 16'h0009, 4'd3},
    {OP_WR, 12'hFFE, 16'h0055, 16'h0000, 4'd7},  // R7 transmitter off
    {OP_CHK,12'h000, 16'h0000, 16'h0000, 4'd7},
    {OP_RD, 12'hFFE, 16'h0000, 16'h0000, 4'd7},
    {OP_WR, 12'hFFF, 16'h0008, 16'h0000, 4'd4},  // R4
    {OP_RD, 12'hFFF, 16'h0000, 16'h000A, 4'd4},
    {OP_WR, 12'hFFE, 16'h1255, 16'h0000, 4'd7},
    {OP_RD, 12'hFFF, 16'h0000, 16'h0009, 4'd7},
    {OP_CHK,12'h000, 16'h0000, 16'h0155, 4'd7},
    {OP_RD, 12'hFFE, 16'h0000, 16'h0055, 4'd2},  // R2
    {OP_WR, 12'hFFE, 16'h0066, 16'h0000, 4'd7},
    {OP_CHK,12'h000, 16'h0000, 16'h0155, 4'd7},
    {OP_ACK,12'h000, 16'h0000, 16'h0000, 4'd8},  // R8
    {OP_RD, 12'hFFF, 16'h0000, 16'h000A, 4'd8},
    {OP_CHK,12'h000, 16'h0000, 16'h0055, 4'd8},
    {OP_WR, 12'h100, 16'hFFFF, 16'h0000, 4'd2},
    {OP_RD, 12'h100, 16'h0000, 16'h0000, 4'd2},
    {OP_RD, 12'hFFF, 16'h0000, 16'h000A, 4'd2},
    {OP_WR, 12'hFFF, 16'h0004, 16'h0000, 4'd4},
    {OP_RD, 12'hFFF, 16'h0000, 16'h0004, 4'd4},
    {OP_WR, 12'hFFD, 16'h0000, 16'h0000, 4'd4},
    {OP_RD, 12'hFFD, 16'h0000, 16'h0000, 4'd4},
    {OP_CHK,12'h000, 16'h0000, 16'h0055, 4'd4}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
    bus_addr = '0; bus_wdata = '0; rx_char = '0;
  endtask

  // drive one operation at a falling edge; reads are checked before the next rise
  task automatic step(input logic [2:0] op, input logic [11:0] a, input logic [15:0] d,
                      input logic [15:0] e, input int req);
    @(negedge clk);
    idle();
    case (op)
      OP_WR:  begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
      OP_RD:  begin bus_rd = 1'b1; bus_addr = a; end
      OP_RX:  begin rx_valid = 1'b1; rx_char = d[7:0]; end
      OP_ACK: tx_ready = 1'b1;
      default: ;
    endcase
    #1;
    if (op == OP_RD)  check(req, bus_rdata, e);
    if (op == OP_CHK) check(req, {7'b0, tx_valid, tx_char}, e);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++)
      step(VEC[i][50:48], VEC[i][47:36], VEC[i][35:20], VEC[i][19:4], int'(VEC[i][3:0]));

    // R6: arrival in the same cycle as a clearing read wins; a new byte overwrites
    step(OP_WR, 12'hFFD, 16'h0008, 16'h0, 6);
    step(OP_RX, 12'h000, 16'h0011, 16'h0, 6);
    @(negedge clk);
    idle();
    bus_rd = 1'b1; bus_addr = 12'hFFC; rx_valid = 1'b1; rx_char = 8'h22;
    #1 check(6, bus_rdata, 16'h0011);
    step(OP_RD, 12'hFFD, 16'h0, 16'h000A, 6);
    step(OP_RD, 12'hFFC, 16'h0, 16'h0022, 6);
    step(OP_RD, 12'hFFD, 16'h0, 16'h0009, 6);
    step(OP_RX, 12'h000, 16'h0033, 16'h0, 6);
    step(OP_RX, 12'h000, 16'h0044, 16'h0, 6);
    step(OP_RD, 12'hFFC, 16'h0, 16'h0044, 6);

    // R8: byte held after handshake, new byte accepted once Done
    step(OP_WR, 12'hFFF, 16'h0008, 16'h0, 8);
    step(OP_WR, 12'hFFE, 16'h00A5, 16'h0, 7);
    step(OP_CHK, 12'h000, 16'h0, 16'h01A5, 7);
    step(OP_ACK, 12'h000, 16'h0, 16'h0, 8);
    step(OP_CHK, 12'h000, 16'h0, 16'h00A5, 8);
    step(OP_WR, 12'hFFE, 16'h003C, 16'h0, 7);
    step(OP_CHK, 12'h000, 16'h0, 16'h013C, 7);

    // R1: asynchronous reset in the middle of a transmission
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1 check(1, {15'b0, tx_valid}, 16'h0000);
    bus_addr = 12'hFFF;
    #1 check(1, bus_rdata, 16'h0000);
    bus_addr = 12'hFFD;
    #1 check(1, bus_rdata, 16'h0000);
    bus_addr = 12'hFFC;
    #1 check(1, bus_rdata, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(OP_CHK, 12'h000, 16'h0, 16'h0000, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule